// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores incoming Ethernet frames in system memory through a circular list of receive descriptors. Each descriptor takes two words at `desc_base + 8*index`: a buffer pointer first, then a control word whose low eleven bits give the buffer capacity minus one and whose top bit asks for an interrupt once the descriptor is filled. For every filled descriptor the block writes two status words at `stat_base + 8*index`. The first word carries the stored length minus one and the error flags. The second word is a hash/CRC slot, which this block always clears.

Frame bytes arrive on a byte stream with a valid/ready handshake and an end-of-frame marker. The block fetches the descriptor at the produce index before it accepts any byte. While bytes arrive, it compares the first six bytes against the broadcast address and the station address. A frame that passes the filter is committed: its status words are written and the produce index moves on. A frame that fails the filter leaves the descriptor free for the next frame. Software reads frames up to the produce index and hands descriptors back by writing the consume index.

Top module: `rx_ring_writer`

## Requirements
- R1: Two memory reads fetch the descriptor at the produce index: the buffer pointer from `desc_base+8*idx` and the control word from the next word. Frame byte k is written to byte address pointer+k as a single-byte write. The byte enable has one bit per byte lane, and the lane is given by address bits 1:0.
- R2: On commit, the word at `stat_base+8*idx` gets the stored byte count minus one in bits 10:0, and the word at `stat_base+8*idx+4` is written with zero.
- R3: Bytes beyond the capacity (control bits 10:0 plus one) are not written. A truncated frame stores exactly the capacity and sets status bit 25, which lies inside the error mask 0x1B800000.
- R4: Filter control bit 1 accepts frames whose destination is FF:FF:FF:FF:FF:FF.
- R5: Filter control bit 5 accepts frames whose six destination bytes equal the station address. `sta_w01` holds bytes 0 and 1, `sta_w23` holds bytes 2 and 3, and `sta_w45` holds bytes 4 and 5, with the lower-numbered byte in bits 7:0 of each register.
- R6: A frame that is rejected, including any frame shorter than six bytes, writes no status, leaves the produce index unchanged and raises no interrupt.
- R7: Each committed frame advances the produce index by one, and the index wraps from `ring_last` to zero.
- R8: When produce+1 (with wrap) equals consume, the ring is full. An arriving frame is then consumed and discarded, and `overrun` is set. A write to the consume index clears `overrun`, and the next frame is stored normally.
- R9: `irq` is high for exactly one cycle, during the second status write, when bit 31 of the committed descriptor's control word was set.
- R10: After reset, `prod_idx`, `cons_idx`, `overrun` and `irq` are zero, and `rx_ready` is low while the ring is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_data | input | 8 | Frame byte |
| rx_valid | input | 1 | Byte valid |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| mem_re | output | 1 | Word read request; data returns next cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| desc_base | input | 32 | Descriptor array base address |
| stat_base | input | 32 | Status array base address |
| ring_last | input | IDX_W | Number of descriptors minus one |
| filt_ctrl | input | 6 | Filter enables (bit 1 broadcast, bit 5 station) |
| sta_w01 | input | 16 | Station address bytes 0,1 |
| sta_w23 | input | 16 | Station address bytes 2,3 |
| sta_w45 | input | 16 | Station address bytes 4,5 |
| cons_we | input | 1 | Consume index write strobe |
| cons_wdata | input | IDX_W | New consume index |
| prod_idx | output | IDX_W | Produce index |
| cons_idx | output | IDX_W | Consume index |
| overrun | output | 1 | Frame dropped on a full ring |
| irq | output | 1 | Descriptor completion pulse |

## Verification
The last byte of a frame is accepted at clock edge E0. The info word is written at E1, and the hash word is written at E2, where the produce index also changes. `irq` is high only in the cycle between E1 and E2. The bench samples at falling edges, so it reads `irq` on the second falling edge after E0 and reads the index and memory on the third. `overrun` is set at the same edge that accepts the first byte of the discarded frame, and it clears at the edge that takes the consume write. The bench samples both one falling edge later.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic             mem_re,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      desc_base,
  input  logic [31:0]      stat_base,
  input  logic [IDX_W-1:0] ring_last,
  input  logic [5:0]       filt_ctrl,
  input  logic [15:0]      sta_w01,
  input  logic [15:0]      sta_w23,
  input  logic [15:0]      sta_w45,
  input  logic             cons_we,
  input  logic [IDX_W-1:0] cons_wdata,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic             overrun,
  output logic             irq
);
  localparam int TRUNC_BIT = 25;

  typedef enum logic [2:0] {S_IDLE, S_FA, S_FC, S_FW, S_RECV, S_ST0, S_ST1, S_DROP} st_t;
  st_t state;

  logic [IDX_W-1:0] prod_q, cons_q, nxt_prod;
  logic             ovr_q, want_irq, trunc, is_bc, is_me;
  logic [31:0]      buf_addr, info_q, info_d, desc_addr, stat_addr, byte_addr;
  logic [LEN_W-1:0] size_m1, len_m1;
  logic [LEN_W:0]   wr_cnt, n_stored;
  logic [2:0]       da_pos;
  logic [7:0]       sta_b;
  logic             hs, fits, full, bc_now, me_now, accept, restart;

  assign nxt_prod  = (prod_q == ring_last) ? '0 : prod_q + 1'b1;
  assign full      = (nxt_prod == cons_q);
  assign desc_addr = desc_base + (32'(prod_q) << 3);
  assign stat_addr = stat_base + (32'(prod_q) << 3);
  assign byte_addr = buf_addr + 32'(wr_cnt);
  assign hs        = rx_valid && rx_ready;
  assign fits      = (wr_cnt <= {1'b0, size_m1});

  always_comb begin
    case (da_pos)
      3'd0:    sta_b = sta_w01[7:0];
      3'd1:    sta_b = sta_w01[15:8];
      3'd2:    sta_b = sta_w23[7:0];
      3'd3:    sta_b = sta_w23[15:8];
      3'd4:    sta_b = sta_w45[7:0];
      default: sta_b = sta_w45[15:8];
    endcase
  end

  assign bc_now = is_bc && (rx_data == 8'hFF);
  assign me_now = is_me && (rx_data == sta_b);
  assign accept = (da_pos >= 3'd5) &&
                  ((filt_ctrl[1] && (da_pos < 3'd6 ? bc_now : is_bc)) ||
                   (filt_ctrl[5] && (da_pos < 3'd6 ? me_now : is_me)));

  assign n_stored = wr_cnt + (fits ? 1'b1 : 1'b0);
  assign len_m1   = LEN_W'(n_stored - 1'b1);
  always_comb begin
    info_d = '0;
    info_d[LEN_W-1:0] = len_m1;
    info_d[TRUNC_BIT] = trunc || !fits;
  end

  assign rx_ready  = (state == S_RECV) || (state == S_DROP) || (state == S_IDLE && full);
  assign mem_re    = (state == S_FA) || (state == S_FC);
  assign mem_we    = (state == S_RECV && hs && fits) || (state == S_ST0) || (state == S_ST1);
  assign mem_be    = (state == S_RECV) ? (4'b0001 << byte_addr[1:0]) : 4'hF;
  assign mem_wdata = (state == S_RECV) ? {4{rx_data}} : (state == S_ST0) ? info_q : 32'h0;
  assign irq       = (state == S_ST1) && want_irq;
  assign prod_idx  = prod_q;
  assign cons_idx  = cons_q;
  assign overrun   = ovr_q;

  always_comb begin
    case (state)
      S_FA:    mem_addr = desc_addr;
      S_FC:    mem_addr = desc_addr + 32'd4;
      S_RECV:  mem_addr = {byte_addr[31:2], 2'b00};
      S_ST0:   mem_addr = stat_addr;
      S_ST1:   mem_addr = stat_addr + 32'd4;
      default: mem_addr = '0;
    endcase
  end

  assign restart = (state == S_FW) || (state == S_RECV && hs && rx_last && !accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      prod_q <= '0;
      cons_q <= '0;
      ovr_q  <= 1'b0;
      info_q <= '0;
    end else begin
      if (cons_we) begin
        cons_q <= cons_wdata;
        ovr_q  <= 1'b0;
      end
      case (state)
        S_IDLE:
          if (full) begin
            if (hs) begin
              ovr_q <= 1'b1;
              if (!rx_last) state <= S_DROP;
            end
          end else state <= S_FA;
        S_FA: state <= S_FC;
        S_FC: state <= S_FW;
        S_FW: state <= S_RECV;
        S_RECV:
          if (hs && rx_last && accept) begin
            info_q <= info_d;
            state  <= S_ST0;
          end
        S_ST0: state <= S_ST1;
        S_ST1: begin
          prod_q <= nxt_prod;
          state  <= S_IDLE;
        end
        S_DROP: if (hs && rx_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr <= '0;
      size_m1  <= '0;
      want_irq <= 1'b0;
      wr_cnt   <= '0;
      trunc    <= 1'b0;
      da_pos   <= '0;
      is_bc    <= 1'b1;
      is_me    <= 1'b1;
    end else begin
      if (state == S_FC) buf_addr <= mem_rdata;
      if (state == S_FW) begin
        size_m1  <= mem_rdata[LEN_W-1:0];
        want_irq <= mem_rdata[31];
      end
      if (restart) begin
        wr_cnt <= '0;
        trunc  <= 1'b0;
        da_pos <= '0;
        is_bc  <= 1'b1;
        is_me  <= 1'b1;
      end else if (state == S_RECV && hs) begin
        if (fits) wr_cnt <= wr_cnt + 1'b1;
        else      trunc  <= 1'b1;
        if (da_pos < 3'd6) begin
          da_pos <= da_pos + 1'b1;
          is_bc  <= bc_now;
          is_me  <= me_now;
        end
      end
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_re,
  input logic             mem_we,
  input logic [3:0]       mem_be,
  input logic [IDX_W-1:0] prod_idx,
  input logic [IDX_W-1:0] ring_last,
  input logic             overrun,
  input logic             irq
);
  assert_single_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

  assert_rw_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_prod_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx != $past(prod_idx)) |->
      (prod_idx == IDX_W'($past(prod_idx) + 1'b1) || prod_idx == '0));

  assert_prod_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prod_idx <= ring_last);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_drop_holds_prod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(prod_idx));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
  .prod_idx(prod_idx), .ring_last(ring_last), .overrun(overrun), .irq(irq)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  localparam int IDX_W = 8;
  localparam logic [31:0] DESC = 32'h100, STAT = 32'h200, BUF = 32'h400;
  localparam int CAP = 64;
  // {kind[15:14], accept[13], trunc[12], len[11:0]}; kind 0 station, 1 broadcast, 2 near-miss
  localparam logic [15:0] VEC [6] = '{16'h2014, 16'h6040, 16'h801E, 16'h3046, 16'h4004, 16'h6006};

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_last = 0, rx_ready;
  logic mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [5:0] filt_ctrl = 6'b100010;
  logic cons_we = 0;
  logic [IDX_W-1:0] cons_wdata = 0, prod_idx, cons_idx;
  logic overrun, irq;
  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0, exp_prod = 0;

  always #5 clk = ~clk;

  rx_ring_writer #(.IDX_W(IDX_W)) i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_ready(rx_ready), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .desc_base(DESC),
    .stat_base(STAT), .ring_last(8'd3), .filt_ctrl(filt_ctrl), .sta_w01(16'h1102),
    .sta_w23(16'h3322), .sta_w45(16'h5544), .cons_we(cons_we), .cons_wdata(cons_wdata),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .overrun(overrun), .irq(irq));

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] fbyte(input int kind, input int j, input logic [7:0] seed);
    logic [7:0] st;
    case (j)
      0: st = 8'h02; 1: st = 8'h11; 2: st = 8'h22;
      3: st = 8'h33; 4: st = 8'h44; default: st = 8'h55;
    endcase
    if (j >= 6) return 8'(seed + 8'(j));
    if (kind == 1) return 8'hFF;
    if (kind == 2 && j == 5) return st ^ 8'h01;
    return st;
  endfunction

  task automatic send(input int kind, input int len, input logic [7:0] seed);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fbyte(kind, j, seed); rx_last = (j == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic set_cons(input int v);
    @(negedge clk);
    cons_we = 1; cons_wdata = IDX_W'(v);
    @(negedge clk);
    cons_we = 0;
  endtask

  task automatic run_frame(input int kind, input int len, input logic [7:0] seed, input bit acc);
    int idx, n;
    logic [31:0] ba, info_before;
    idx = exp_prod;
    ba = BUF + 32'(idx * 128);
    info_before = mem[(STAT + 32'(idx * 8)) >> 2];
    n = (len > CAP) ? CAP : len;
    send(kind, len, seed);
    @(negedge clk);
    chk(acc && idx == 1 ? "R9 irq pulse" : "R6/R9 no irq", {31'b0, irq}, {31'b0, acc && idx == 1});
    @(negedge clk);
    if (acc) begin
      exp_prod = (idx == 3) ? 0 : idx + 1;
      chk("R7 produce index", 32'(prod_idx), 32'(exp_prod));
      chk("R2 length field", {21'b0, mem[(STAT + 32'(idx * 8)) >> 2][10:0]}, 32'(n - 1));
      chk("R3 truncation bit25", {31'b0, mem[(STAT + 32'(idx * 8)) >> 2][25]}, {31'b0, len > CAP});
      chk("R2 hash word zero", mem[(STAT + 32'(idx * 8) + 4) >> 2], 32'h0);
      chk("R1 first byte", {24'b0, rd_byte(ba)}, {24'b0, fbyte(kind, 0, seed)});
      chk("R1 last stored byte", {24'b0, rd_byte(ba + 32'(n - 1))}, {24'b0, fbyte(kind, n - 1, seed)});
      if (len > CAP) chk("R3 byte past capacity untouched", {24'b0, rd_byte(ba + 32'(CAP))}, 32'hEE);
    end else begin
      chk("R6 produce index held", 32'(prod_idx), 32'(exp_prod));
      chk("R6 status untouched", mem[(STAT + 32'(idx * 8)) >> 2], info_before);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int w = 0; w < 1024; w++) mem[w] = 32'hEEEE_EEEE;
    for (int d = 0; d < 4; d++) begin
      mem[(DESC >> 2) + 2 * d]     = BUF + 32'(d * 128);
      mem[(DESC >> 2) + 2 * d + 1] = 32'(CAP - 1) | (d == 1 ? 32'h8000_0000 : 32'h0);
      mem[(STAT >> 2) + 2 * d]     = 32'hA5A5_A5A5;
      mem[(STAT >> 2) + 2 * d + 1] = 32'hA5A5_A5A5;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset prod", 32'(prod_idx), 0);
    chk("R10 reset cons", 32'(cons_idx), 0);
    chk("R10 reset overrun", {31'b0, overrun}, 0);
    chk("R10 reset irq/ready", {30'b0, irq, rx_ready}, 0);
    rst_n = 1;

    // R1..R7, R9 table walk: accepted, rejected, truncated, short and wrap cases
    for (int i = 0; i < 6; i++) begin
      run_frame(int'(VEC[i][15:14]), int'(VEC[i][11:0]), 8'(i * 16 + 3), VEC[i][13]);
      set_cons(exp_prod);
    end
    chk("R7 wrap to zero", 32'(prod_idx), 0);

    // R4 / R5 filter enable bits taken one at a time
    filt_ctrl = 6'b000010;
    run_frame(0, 10, 8'h40, 0);
    filt_ctrl = 6'b100000;
    run_frame(1, 10, 8'h50, 0);
    run_frame(0, 10, 8'h60, 1);
    filt_ctrl = 6'b100010;
    run_frame(2, 12, 8'h61, 0);
    set_cons(exp_prod);

    // R8 full ring drop and recovery
    for (int k = 0; k < 3; k++) run_frame(1, 8 + k, 8'(8'h70 + k), 1);
    chk("R8 no overrun before drop", {31'b0, overrun}, 0);
    run_frame(0, 9, 8'h80, 0);
    chk("R8 overrun set on drop", {31'b0, overrun}, 1);
    set_cons(exp_prod);
    chk("R8 overrun cleared by consume write", {31'b0, overrun}, 0);
    run_frame(0, 9, 8'h90, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule